// File: doc/BRIEF.md
# PLL Lock Monitor

This block judges whether a phase-locked loop has settled. Each phase-detector cycle delivers one strobe from the divided reference path and one from the divided feedback path. A fast sampling clock counts how far apart the two strobes arrive. A cycle is good when that distance is below a tight acquire threshold. After enough good cycles in a row, the block raises an active-high lock flag.

Once the flag is up, it stays up through small disturbances. It falls only when a cycle's error reaches a looser release threshold, or when one strobe arrives without its partner. The precision input selects how many consecutive good cycles are needed. Power-down from either the pin or software returns the monitor to its reset condition.

Both strobes are single-cycle pulses that are already synchronous to the sampling clock. Thresholds and the partner timeout are parameters given in sampling-clock cycles. The defaults are ACQ_TH = 4, REL_TH = 8 and TIMEOUT = 20.

Top module: `pll_lock_monitor`

## Requirements
- R1: After a synchronous reset, `locked` is 0 and the consecutive-good count is 0, so a full run of good cycles is needed before `locked` rises.
- R2: The error of a cycle is the number of sampling cycles from the first strobe to its partner, whichever input comes first. Strobes sampled on the same edge give an error of 0. A cycle is good when its error is below ACQ_TH.
- R3: With `precise` = 0, `locked` rises on the third consecutive good cycle.
- R4: With `precise` = 1, five consecutive good cycles are needed, and the fourth one leaves `locked` at 0.
- R5: A cycle whose error is ACQ_TH or more clears the consecutive-good count.
- R6: While `locked` is 1, a cycle whose error is below REL_TH leaves it at 1, including errors from ACQ_TH to REL_TH-1.
- R7: A cycle whose error is REL_TH or more drops `locked` to 0.
- R8: A strobe whose partner has not arrived within TIMEOUT sampling cycles counts as a large error, and `locked` falls on the sampling edge TIMEOUT cycles after the lone strobe. A second strobe on the same input before the partner arrives also counts as a large error.
- R9: While `pd_pin` or `pd_sw` is high, `locked` is 0 and the count is held at 0. Counting restarts from zero after both are released.
- R10: `locked` changes on the same sampling edge that captures the strobe completing the cycle, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_strobe | input | 1 | One-cycle pulse from the divided reference |
| fb_strobe | input | 1 | One-cycle pulse from the divided feedback |
| precise | input | 1 | 0: three good cycles to lock; 1: five |
| pd_pin | input | 1 | Hardware power-down, active high |
| pd_sw | input | 1 | Software power-down, active high |
| locked | output | 1 | Lock flag, active high |

## Verification
The flag is registered and is computed from the strobe seen at an edge, so each verdict is visible one sampling edge after the closing strobe is driven. The bench drives every input on falling edges and reads `locked` on the following falling edge. The R10 check reads the flag once while the closing strobe is still pending and once just after it is sampled. The timeout check counts falling edges from the lone strobe: it expects the flag still high after TIMEOUT edges and low after TIMEOUT+1. Power-down effects are visible at the first falling edge after the power-down request.

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int ACQ_TH      = 4,
  parameter int REL_TH      = 8,
  parameter int TIMEOUT     = 20,
  parameter int LOCK_CNT_LO = 3,
  parameter int LOCK_CNT_HI = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_strobe,
  input  logic fb_strobe,
  input  logic precise,
  input  logic pd_pin,
  input  logic pd_sw,
  output logic locked
);
  localparam int GAP_W = $clog2(TIMEOUT + 1);
  localparam int CNT_W = $clog2(LOCK_CNT_HI + 1);
  localparam logic [GAP_W-1:0] ACQ_G = GAP_W'(ACQ_TH);
  localparam logic [GAP_W-1:0] REL_G = GAP_W'(REL_TH);
  localparam logic [GAP_W-1:0] TO_G  = GAP_W'(TIMEOUT);
  localparam logic [CNT_W-1:0] LO_C  = CNT_W'(LOCK_CNT_LO);
  localparam logic [CNT_W-1:0] HI_C  = CNT_W'(LOCK_CNT_HI);

  logic             waiting, first_ref;
  logic [GAP_W-1:0] gap;
  logic [CNT_W-1:0] good_cnt, cnt_next;

  wire hold        = rst | pd_pin | pd_sw;
  wire both_now    = !waiting && ref_strobe && fb_strobe;
  wire partner     = waiting && (first_ref ? fb_strobe : ref_strobe);
  wire repeat_edge = waiting && !partner && (first_ref ? ref_strobe : fb_strobe);
  wire expired     = waiting && !partner && !repeat_edge && (gap == TO_G);
  wire measured    = both_now | partner;
  wire cyc_done    = measured | repeat_edge | expired;
  wire [GAP_W-1:0] cyc_err = partner ? gap : '0;
  wire cyc_good    = measured && (cyc_err < ACQ_G);
  wire cyc_big     = repeat_edge | expired | (measured && (cyc_err >= REL_G));
  wire [CNT_W-1:0] need = precise ? HI_C : LO_C;

  assign cnt_next = (good_cnt >= HI_C) ? good_cnt : good_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (hold) begin
      waiting   <= 1'b0;
      first_ref <= 1'b0;
      gap       <= '0;
    end else if (!waiting) begin
      if (ref_strobe ^ fb_strobe) begin
        waiting   <= 1'b1;
        first_ref <= ref_strobe;
        gap       <= GAP_W'(1);
      end
    end else if (cyc_done) begin
      waiting <= 1'b0;
      gap     <= '0;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (hold) begin
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (cyc_done) begin
      if (cyc_good) begin
        good_cnt <= cnt_next;
        if (cnt_next >= need) locked <= 1'b1;
      end else begin
        good_cnt <= '0;
        if (cyc_big) locked <= 1'b0;
      end
    end
  end

  initial AST_THRESH_ORDER: assert (ACQ_TH < REL_TH && REL_TH <= TIMEOUT && LOCK_CNT_LO <= LOCK_CNT_HI); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!locked && good_cnt == '0)); // R1
  AST_RISE_ON_GOOD: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(cyc_good)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    good_cnt <= HI_C); // R4
  AST_BAD_CLEARS_CNT: assert property (@(posedge clk) disable iff (rst)
    (cyc_done && !cyc_good) |=> good_cnt == '0); // R5
  AST_HOLD_LOCK: assert property (@(posedge clk) disable iff (rst)
    (locked && !pd_pin && !pd_sw && !(cyc_done && cyc_big)) |=> locked); // R6
  AST_DROP_ON_BIG: assert property (@(posedge clk) disable iff (rst)
    (cyc_done && cyc_big) |=> !locked); // R7
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    gap <= TO_G); // R8
  AST_PD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (pd_pin || pd_sw) |=> (!locked && good_cnt == '0)); // R9
endmodule

// File: tb/pll_lock_monitor_tb.sv
module pll_lock_monitor_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int ACQ = 4, REL = 8, TMO = 20;

  logic clk = 1'b0, rst = 1'b1, ref_s = 1'b0, fb_s = 1'b0;
  logic precise = 1'b0, pd_pin = 1'b0, pd_sw = 1'b0;
  logic locked;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_lock_monitor #(.ACQ_TH(ACQ), .REL_TH(REL), .TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst(rst), .ref_strobe(ref_s), .fb_strobe(fb_s),
    .precise(precise), .pd_pin(pd_pin), .pd_sw(pd_sw), .locked(locked));

  task automatic chk(input logic exp, input string tag);
    n_chk++;
    if (locked !== exp) begin
      n_fail++;
      $display("FAIL %s: locked=%b expected=%b at %0t", tag, locked, exp, $time);
    end
  endtask

  task automatic pd_cycle(input bit ref_first, input int gap);
    @(negedge clk);
    if (gap == 0) begin
      ref_s = 1'b1; fb_s = 1'b1;
      @(negedge clk); ref_s = 1'b0; fb_s = 1'b0;
    end else begin
      if (ref_first) ref_s = 1'b1; else fb_s = 1'b1;
      @(negedge clk); ref_s = 1'b0; fb_s = 1'b0;
      repeat (gap - 1) @(negedge clk);
      if (ref_first) fb_s = 1'b1; else ref_s = 1'b1;
      @(negedge clk); ref_s = 1'b0; fb_s = 1'b0;
    end
  endtask

  task automatic goods(input int n);
    for (int i = 0; i < n; i++) pd_cycle(i[0], 1);
  endtask

  task automatic clear_state();
    @(negedge clk); pd_sw = 1'b1;
    @(negedge clk); pd_sw = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); chk(1'b0, "R1 after reset");
    goods(3); chk(1'b1, "R3 lock before mid reset");
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk(1'b0, "R1 mid-run reset");
    goods(2); chk(1'b0, "R1 count cleared by reset");
  endtask

  task automatic t_acquire();
    clear_state(); precise = 1'b0;
    pd_cycle(1'b1, 0); chk(1'b0, "R2 simultaneous good 1");
    pd_cycle(1'b0, ACQ - 1); chk(1'b0, "R2 fb first good 2");
    @(negedge clk); ref_s = 1'b1;
    @(negedge clk); ref_s = 1'b0;
    @(negedge clk); fb_s = 1'b1;
    chk(1'b0, "R10 not yet sampled");
    @(negedge clk); fb_s = 1'b0;
    chk(1'b1, "R10 R3 lock on third good");
  endtask

  task automatic t_hold_release();
    pd_cycle(1'b1, REL - 1); chk(1'b1, "R6 error REL-1 holds");
    pd_cycle(1'b0, ACQ); chk(1'b1, "R6 error ACQ holds");
    pd_cycle(1'b1, REL); chk(1'b0, "R7 error REL drops");
  endtask

  task automatic t_count_clear();
    clear_state();
    goods(2);
    pd_cycle(1'b1, ACQ); chk(1'b0, "R5 bad cycle after two goods");
    goods(2); chk(1'b0, "R5 count restarted");
    pd_cycle(1'b0, ACQ - 1); chk(1'b1, "R5 R2 third good at ACQ-1");
  endtask

  task automatic t_timeout();
    @(negedge clk); ref_s = 1'b1;
    @(negedge clk); ref_s = 1'b0;
    repeat (TMO - 1) @(negedge clk);
    chk(1'b1, "R8 still locked inside window");
    @(negedge clk); chk(1'b0, "R8 timeout drops lock");
    goods(3); chk(1'b1, "R8 relock after timeout");
  endtask

  task automatic t_repeat_edge();
    @(negedge clk); fb_s = 1'b1;
    @(negedge clk); fb_s = 1'b0;
    @(negedge clk); fb_s = 1'b1;
    @(negedge clk); fb_s = 1'b0;
    chk(1'b0, "R8 repeated edge drops lock");
  endtask

  task automatic t_precise();
    clear_state(); precise = 1'b1;
    goods(4); chk(1'b0, "R4 four goods not enough");
    pd_cycle(1'b1, 2); chk(1'b1, "R4 fifth good locks");
    precise = 1'b0;
  endtask

  task automatic t_powerdown();
    @(negedge clk); pd_pin = 1'b1;
    @(negedge clk); pd_pin = 1'b0;
    chk(1'b0, "R9 pin power-down clears");
    goods(2); chk(1'b0, "R9 count cleared by pin");
    goods(1); chk(1'b1, "R9 relock after pin");
    @(negedge clk); pd_sw = 1'b1;
    goods(3); chk(1'b0, "R9 held off by software power-down");
    @(negedge clk); pd_sw = 1'b0;
    goods(2); chk(1'b0, "R9 count restarts after release");
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_hold_release();
    t_count_clear();
    t_timeout();
    t_repeat_edge();
    t_precise();
    t_powerdown();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule